// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating voltmeter. A start request clears a four-digit decimal counter and a phase register, and selects the unknown input as the integrator source. Once the integrator output is seen to leave zero, the block opens its counting gate and counts a fixed run-up of 10000 clocks. The decade chain rolls over from 9999 and produces a carry. That carry moves the source select to the reverse-polarity reference. Counting then restarts from zero. It stops when the integrator is seen back at zero.

The count taken during the run-down, n2, is the reading. The run-up count n1 is fixed at 10000, so the input equals Vref·n2/10000 and does not depend on the clock rate. The integrator, comparator, analog switch and display sit outside the block. The comparator output arrives asynchronously and passes through a synchroniser before any decision uses it. A run-down that would pass 9999 ends the conversion with an overflow flag, and the previous reading is kept.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset, `sel_ref_o`, `gate_o`, `done_o` and `ovf_o` are 0 and `result_o` is 0.
- R2: A start in idle clears the counter and the phase register and leaves `sel_ref_o` at 0 (input selected). `gate_o` stays 0 until the synchronised comparator reports non-zero. With the default two synchroniser stages, `gate_o` rises on the third rising edge after `cmp_nz_i` goes high.
- R3: Each counter digit holds only 0 to 9 and carries into the next digit. `result_o[3:0]` is units, `[7:4]` tens, `[11:8]` hundreds and `[15:12]` thousands, each in BCD.
- R4: The run-up lasts exactly 10000 clocks with `gate_o`=1 and `sel_ref_o`=0. The rollover carry from 9999 then sets `sel_ref_o` to 1 (reference selected), and the counter restarts at zero.
- R5: The reading is the number of gated reference-phase clocks. If `cmp_nz_i` falls K clocks after `sel_ref_o` is first seen high, `result_o` becomes the BCD value of K+2, because of the synchroniser latency.
- R6: When the synchronised comparator reaches zero in the reference phase, `result_o` is loaded and `done_o` is high for exactly one clock. In that same clock `sel_ref_o` and `gate_o` return to 0.
- R7: If the reference count is at 9999 and the comparator is still non-zero, the conversion stops. `ovf_o` is set, `done_o` stays 0, `result_o` keeps its previous value, and the next start clears `ovf_o`.
- R8: A start request during a conversion has no effect on the run-up length or on the reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (honoured only when idle) |
| cmp_nz_i | input | 1 | Asynchronous comparator: 1 while the integrator output is away from zero |
| sel_ref_o | output | 1 | Source select: 0 = unknown input, 1 = reverse reference |
| gate_o | output | 1 | Counting gate open |
| result_o | output | 16 | Latched BCD reading, four digits |
| done_o | output | 1 | One-clock pulse when a new reading is loaded |
| ovf_o | output | 1 | Run-down exceeded the counter range |

## Verification
The assertions check these on every clock:
- every digit stays in decimal range;
- a rollover carry always returns the counter to zero;
- the reference is selected only after a carry;
- no count is taken while waiting for the comparator;
- `done_o` is a single-clock pulse;
- an overflow leaves the reading untouched.

Only the bench scenarios can show the rest:
- the exact run-up length of 10000 clocks;
- the synchroniser latency before the gate opens;
- the reading for specific run-down times, including both sides of the 9999 limit;
- that a start issued mid-conversion changes nothing.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  localparam int BCD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUNUP,
    ST_RUNDOWN
  } dsadc_state_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter
  import dsadc_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_i,
  input  logic                        en_i,
  output logic [NUM_DIGITS*BCD_W-1:0] count_o,
  output logic                        carry_o,
  output logic                        max_o
);
  localparam int CW = NUM_DIGITS * BCD_W;

  logic [NUM_DIGITS:0]   inc_chain;
  logic [NUM_DIGITS-1:0] nine;

  assign inc_chain[0] = en_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic [BCD_W-1:0] dig_q;

    assign nine[g]           = (dig_q == BCD_W'(9));
    assign inc_chain[g+1]    = inc_chain[g] & nine[g];
    assign count_o[g*BCD_W +: BCD_W] = dig_q;

    always_ff @(posedge clk) begin
      if (rst || clr_i)      dig_q <= '0;
      else if (inc_chain[g]) dig_q <= nine[g] ? '0 : dig_q + BCD_W'(1);
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
      dig_q <= BCD_W'(9)); // R3
  end

  assign carry_o = inc_chain[NUM_DIGITS];
  assign max_o   = &nine;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (carry_o && !clr_i) |=> (count_o == CW'(0))); // R4
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          cmp_s_i,
  input  logic [CW-1:0] count_i,
  input  logic          cnt_carry_i,
  input  logic          cnt_max_i,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          sel_ref_o,
  output logic          gate_o,
  output logic [CW-1:0] result_o,
  output logic          done_o,
  output logic          ovf_o
);
  dsadc_state_e state_q;

  assign cnt_clr_o = (state_q == ST_IDLE) && start_i;
  assign cnt_en_o  = (state_q == ST_RUNUP) ||
                     ((state_q == ST_RUNDOWN) && cmp_s_i && !cnt_max_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_ref_o <= 1'b0;
      gate_o    <= 1'b0;
      result_o  <= '0;
      done_o    <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_WAIT;
          sel_ref_o <= 1'b0;
          gate_o    <= 1'b0;
          ovf_o     <= 1'b0;
        end
        ST_WAIT: if (cmp_s_i) begin
          state_q <= ST_RUNUP;
          gate_o  <= 1'b1;
        end
        ST_RUNUP: if (cnt_carry_i) begin
          state_q   <= ST_RUNDOWN;
          sel_ref_o <= 1'b1;
        end
        ST_RUNDOWN: begin
          if (!cmp_s_i) begin
            result_o  <= count_i;
            done_o    <= 1'b1;
            gate_o    <= 1'b0;
            sel_ref_o <= 1'b0;
            state_q   <= ST_IDLE;
          end else if (cnt_max_i) begin
            ovf_o     <= 1'b1;
            gate_o    <= 1'b0;
            sel_ref_o <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_GATE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> !cnt_en_o); // R2
  AST_REF_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ref_o) |-> $past(cnt_carry_i)); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!gate_o && !sel_ref_o)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> ($stable(result_o) && !done_o)); // R7
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW = NUM_DIGITS * BCD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          cmp_nz_i,
  output logic          sel_ref_o,
  output logic          gate_o,
  output logic [CW-1:0] result_o,
  output logic          done_o,
  output logic          ovf_o
);
  logic          cmp_s;
  logic          cnt_clr, cnt_en, cnt_carry, cnt_max;
  logic [CW-1:0] count;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_nz_i),
    .q_o (cmp_s)
  );

  dsadc_bcd_counter #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .count_o (count),
    .carry_o (cnt_carry),
    .max_o   (cnt_max)
  );

  dsadc_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cmp_s_i     (cmp_s),
    .count_i     (count),
    .cnt_carry_i (cnt_carry),
    .cnt_max_i   (cnt_max),
    .cnt_clr_o   (cnt_clr),
    .cnt_en_o    (cnt_en),
    .sel_ref_o   (sel_ref_o),
    .gate_o      (gate_o),
    .result_o    (result_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o)
  );
endmodule

// File: tb/dsadc_ctrl_bench.sv
module dsadc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NV         = 4;
  localparam int K_TAB [NV] = '{0, 7, 1232, 4998};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        cmp_nz_i = 1'b0;
  logic        sel_ref_o, gate_o, done_o, ovf_o;
  logic [15:0] result_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  dsadc_ctrl u_dsadc_ctrl (
    .clk (clk), .rst (rst), .start_i (start_i), .cmp_nz_i (cmp_nz_i),
    .sel_ref_o (sel_ref_o), .gate_o (gate_o), .result_o (result_o),
    .done_o (done_o), .ovf_o (ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  // One conversion: rundown comparator falls k clocks after sel_ref is seen high.
  task automatic convert(input int k, input bit poke_start, input bit ovf_clear_chk,
                         output int n1, output bit got_done, output bit got_ovf);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (ovf_clear_chk) check("R7", "ovf cleared by start", ovf_o, 0);
    repeat (4) @(negedge clk);
    check("R2", "gate closed before comparator", gate_o, 0);
    check("R2", "input selected after start", sel_ref_o, 0);
    cmp_nz_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2", "gate still closed in sync latency", gate_o, 0);
    @(negedge clk);
    check("R2", "gate open after sync", gate_o, 1);
    n1 = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      start_i = (poke_start && n1 == 50) ? 1'b1 : 1'b0;
      if (sel_ref_o) break;
      if (gate_o) n1++;
    end
    start_i = 1'b0;
    repeat (k) @(negedge clk);
    cmp_nz_i = 1'b0;
    got_done = 1'b0;
    got_ovf  = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done_o) begin got_done = 1'b1; break; end
      if (ovf_o)  begin got_ovf  = 1'b1; break; end
    end
  endtask

  initial begin
    int  n1;
    bit  gd, go;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "sel_ref after reset", sel_ref_o, 0);
    check("R1", "gate after reset", gate_o, 0);
    check("R1", "done after reset", done_o, 0);
    check("R1", "ovf after reset", ovf_o, 0);
    check("R1", "result after reset", result_o, 0);

    for (int v = 0; v < NV; v++) begin
      convert(K_TAB[v], v == 2, 1'b0, n1, gd, go);
      check("R4", "run-up length", n1, 10000);
      check("R6", "done seen", gd, 1);
      check("R5", "reading (R3 BCD)", result_o, to_bcd(K_TAB[v] + 2));
      if (v == 2) check("R8", "start mid-run ignored", result_o, to_bcd(1234));
      @(negedge clk);
      check("R6", "done one clock", done_o, 0);
      check("R6", "gate closed after done", gate_o, 0);
      check("R6", "input selected after done", sel_ref_o, 0);
    end

    // Largest valid reading
    convert(9997, 1'b0, 1'b0, n1, gd, go);
    check("R5", "reading at 9999", result_o, to_bcd(9999));
    check("R7", "no overflow at 9999", ovf_o, 0);

    // One clock longer: overflow
    convert(9998, 1'b0, 1'b0, n1, gd, go);
    check("R7", "overflow raised", go, 1);
    check("R7", "no done on overflow", gd, 0);
    check("R7", "previous reading kept", result_o, to_bcd(9999));
    @(negedge clk);
    check("R7", "overflow held", ovf_o, 1);
    check("R7", "gate closed on overflow", gate_o, 0);

    // Fresh conversion after overflow
    convert(7, 1'b0, 1'b1, n1, gd, go);
    check("R4", "run-up after overflow", n1, 10000);
    check("R5", "reading after overflow", result_o, to_bcd(9));
    check("R7", "ovf stays clear", ovf_o, 0);

    finish_run();
  end
endmodule